// File: doc/BRIEF.md
# Paged Register Window Bridge on a Management Bus

This block sits on the device side of a management bus. At one management PHY address it offers a handful of 16-bit registers. Through these registers a host reaches a far larger internal register space. That space is split into pages, and each internal register is up to 64 bits wide. The block takes register-level read and write strobes. Each strobe carries a PHY address, a 5-bit register number and 16 bits of data. The serial bit protocol is handled elsewhere.

The host accesses the internal space in a fixed order:

1. It selects a page.
2. For a write, it loads up to four 16-bit staging words.
3. It writes a command that holds a register offset and one request bit.
4. It polls the command register until the request bit reads zero.
5. For a read, it collects the fetched value from the staging words.

Internally the block raises a single request on a request/acknowledge register bus. It holds that request until the responder acknowledges it. The responder may take any number of cycles.

Top module: `mgmt_window_bridge`

## Requirements
- R1: After synchronous reset, every window register reads 0x0000, no internal request is raised and no read response is given.
- R2: The page register is at address 0x10. It holds the page number in bits [15:8] and an enable flag in bit 0. Its bits [7:1] read as zero. It can be written at any time.
- R3: The command register is at address 0x11. It holds the internal offset in bits [15:8], the write request in bit 0 and the read request in bit 1. Its bits [7:2] read as zero. A request bit reads as 1 from the cycle after a command starts until the internal acknowledge, and reads as 0 after that.
- R4: Each accepted command raises exactly one internal request. The request is held with page, offset, direction and write data unchanged until the cycle it is acknowledged, and is dropped in the following cycle.
- R5: Staging word k is at address 0x18+k, for k from 0 to 3, and carries bits [16k+15:16k] of the internal value. A host read of an owned address returns its data with a valid pulse on the clock edge after the strobe.
- R6: An internal write carries the staging words and the page as they stood when the command was written. A page write while the access is pending does not change that access.
- R7: When an internal read is acknowledged, all staging words are loaded from the internal read data. They are loaded on no other cycle.
- R8: Strobes carrying any other PHY address produce no response and change no state.
- R9: A command with both request bits set starts no access and leaves both request bits at 0. Its offset field is still stored.
- R10: Owned addresses other than 0x10, 0x11 and 0x18 to 0x1B read as 0x0000. Writes to them are dropped.
- R11: While an access is pending, writes to the command register and to the staging words are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mg_wr | input | 1 | Management register write strobe |
| mg_rd | input | 1 | Management register read strobe |
| mg_phy | input | 5 | Management PHY address of the strobe |
| mg_reg | input | 5 | Management register number |
| mg_wdata | input | WORD_W | Management write data |
| mg_rvalid | output | 1 | Read response valid, one cycle after an owned read |
| mg_rdata | output | WORD_W | Read response data |
| ib_req | output | 1 | Internal bus request, held until acknowledged |
| ib_we | output | 1 | Internal access direction, 1 for write |
| ib_page | output | PAGE_W | Internal page of the access |
| ib_offset | output | OFS_W | Internal register offset of the access |
| ib_wdata | output | WORD_W*NUM_WORDS | Internal write value |
| ib_ack | input | 1 | Internal bus acknowledge, one cycle |
| ib_rdata | input | WORD_W*NUM_WORDS | Internal read value, sampled with the acknowledge |

## Verification
The hardest situation to reach is host traffic that lands while an internal access is still pending. Examples are a page change, a second command or a staging write arriving in the gap between request and acknowledge. Each of these must be dropped or must leave the pending access untouched. The bench's responder model changes its acknowledge latency on every access, so stretches of several cycles leave room for such strobes. A pseudo-random host sequence then mixes page writes, staging writes, commands, rejected commands and foreign-address strobes. Many of these fall inside a busy window. The internal read data carries junk on every cycle without an acknowledge, so a stray staging load shows up on readback.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
  // Window register numbers; the host software depends on these positions.
  localparam logic [4:0] RA_PAGE  = 5'h10;
  localparam logic [4:0] RA_CMD   = 5'h11;
  localparam logic [4:0] RA_DATA0 = 5'h18;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_PAGE,
    SEL_CMD,
    SEL_DATA
  } win_sel_e;
endpackage

// File: rtl/mwb_decode.sv
module mwb_decode
  import mwb_pkg::*;
#(
  parameter logic [4:0] OWN_PHY   = 5'd30,
  parameter int         NUM_WORDS = 4,
  localparam int        IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic [4:0]       phy,
  input  logic [4:0]       reg_a,
  output logic             hit,
  output win_sel_e         sel,
  output logic [IDX_W-1:0] widx
);
  localparam logic [5:0] DATA_END = 6'(RA_DATA0) + 6'(NUM_WORDS);

  // R8: only the owned PHY address hits
  always_comb begin
    hit  = (phy == OWN_PHY);
    sel  = SEL_NONE;
    widx = '0;
    if (reg_a == RA_PAGE) begin
      sel = SEL_PAGE;
    end else if (reg_a == RA_CMD) begin
      sel = SEL_CMD;
    end else if (reg_a >= RA_DATA0 && {1'b0, reg_a} < DATA_END) begin
      sel  = SEL_DATA;
      widx = IDX_W'(reg_a - RA_DATA0);
    end
  end
endmodule

// File: rtl/mwb_stage.sv
module mwb_stage #(
  parameter int  WORD_W    = 16,
  parameter int  NUM_WORDS = 4,
  localparam int IDX_W     = $clog2(NUM_WORDS),
  localparam int DATA_W    = WORD_W * NUM_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  widx,
  input  logic [WORD_W-1:0] wdata,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic [DATA_W-1:0] words
);
  logic [WORD_W-1:0] word_q [NUM_WORDS];

  // R5/R7: word g covers bits [g*WORD_W +: WORD_W]; an internal read load wins
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q[g] <= '0;
      end else if (load_en) begin
        word_q[g] <= load_data[g*WORD_W +: WORD_W];
      end else if (wr_en && widx == IDX_W'(g)) begin
        word_q[g] <= wdata;
      end
    end
    assign words[g*WORD_W +: WORD_W] = word_q[g];
  end

  assign rd_word = word_q[rd_idx];
endmodule

// File: rtl/mwb_seq.sv
module mwb_seq #(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 8,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [OFS_W-1:0]  cmd_ofs,
  input  logic [1:0]        cmd_op,
  input  logic [PAGE_W-1:0] page_in,
  input  logic [DATA_W-1:0] stage_in,
  input  logic              ib_ack,
  output logic              busy,
  output logic              wr_busy,
  output logic              rd_busy,
  output logic [OFS_W-1:0]  ofs_q,
  output logic              load_en,
  output logic              ib_req,
  output logic              ib_we,
  output logic [PAGE_W-1:0] ib_page,
  output logic [OFS_W-1:0]  ib_offset,
  output logic [DATA_W-1:0] ib_wdata
);
  logic start;
  logic done;

  assign busy = wr_busy | rd_busy;
  // R9: exactly one request bit must be set; R11: nothing accepted while busy
  assign start   = cmd_wr && !busy && (cmd_op[0] ^ cmd_op[1]);
  assign done    = ib_req && ib_ack;
  assign load_en = done && rd_busy;   // R7

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_busy   <= 1'b0;
      rd_busy   <= 1'b0;
      ofs_q     <= '0;
      ib_req    <= 1'b0;
      ib_we     <= 1'b0;
      ib_page   <= '0;
      ib_offset <= '0;
      ib_wdata  <= '0;
    end else begin
      if (cmd_wr && !busy) begin
        ofs_q <= cmd_ofs;
      end
      if (start) begin
        // R6: page and staged value frozen at command time
        wr_busy   <= cmd_op[0];
        rd_busy   <= cmd_op[1];
        ib_req    <= 1'b1;
        ib_we     <= cmd_op[0];
        ib_page   <= page_in;
        ib_offset <= cmd_ofs;
        ib_wdata  <= stage_in;
      end else if (done) begin
        // R3/R4: busy bits and request drop after the acknowledge
        wr_busy <= 1'b0;
        rd_busy <= 1'b0;
        ib_req  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mgmt_window_bridge.sv
module mgmt_window_bridge
  import mwb_pkg::*;
#(
  parameter logic [4:0] OWN_PHY   = 5'd30,
  parameter int         PAGE_W    = 8,
  parameter int         OFS_W     = 8,
  parameter int         WORD_W    = 16,
  parameter int         NUM_WORDS = 4,
  localparam int        DATA_W    = WORD_W * NUM_WORDS,
  localparam int        IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mg_wr,
  input  logic              mg_rd,
  input  logic [4:0]        mg_phy,
  input  logic [4:0]        mg_reg,
  input  logic [WORD_W-1:0] mg_wdata,
  output logic              mg_rvalid,
  output logic [WORD_W-1:0] mg_rdata,
  output logic              ib_req,
  output logic              ib_we,
  output logic [PAGE_W-1:0] ib_page,
  output logic [OFS_W-1:0]  ib_offset,
  output logic [DATA_W-1:0] ib_wdata,
  input  logic              ib_ack,
  input  logic [DATA_W-1:0] ib_rdata
);
  logic              hit;
  win_sel_e          sel;
  logic [IDX_W-1:0]  widx;
  logic              wr_hit;
  logic              rd_hit;
  logic [PAGE_W-1:0] page_q;
  logic              en_q;
  logic              busy;
  logic              wr_busy;
  logic              rd_busy;
  logic [OFS_W-1:0]  ofs_q;
  logic              load_en;
  logic [WORD_W-1:0] stage_word;
  logic [DATA_W-1:0] stage_all;
  logic [WORD_W-1:0] rd_val;

  mwb_decode #(.OWN_PHY(OWN_PHY), .NUM_WORDS(NUM_WORDS)) u_dec (
    .phy   (mg_phy),
    .reg_a (mg_reg),
    .hit   (hit),
    .sel   (sel),
    .widx  (widx)
  );

  assign wr_hit = mg_wr && hit;
  assign rd_hit = mg_rd && hit;

  // R2: page latch is writable at any time
  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      en_q   <= 1'b0;
    end else if (wr_hit && sel == SEL_PAGE) begin
      page_q <= mg_wdata[8 +: PAGE_W];
      en_q   <= mg_wdata[0];
    end
  end

  mwb_stage #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_hit && sel == SEL_DATA && !busy),
    .widx      (widx),
    .wdata     (mg_wdata),
    .load_en   (load_en),
    .load_data (ib_rdata),
    .rd_idx    (widx),
    .rd_word   (stage_word),
    .words     (stage_all)
  );

  mwb_seq #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (wr_hit && sel == SEL_CMD),
    .cmd_ofs   (mg_wdata[8 +: OFS_W]),
    .cmd_op    (mg_wdata[1:0]),
    .page_in   (page_q),
    .stage_in  (stage_all),
    .ib_ack    (ib_ack),
    .busy      (busy),
    .wr_busy   (wr_busy),
    .rd_busy   (rd_busy),
    .ofs_q     (ofs_q),
    .load_en   (load_en),
    .ib_req    (ib_req),
    .ib_we     (ib_we),
    .ib_page   (ib_page),
    .ib_offset (ib_offset),
    .ib_wdata  (ib_wdata)
  );

  // R10: unimplemented addresses read zero
  always_comb begin
    rd_val = '0;
    case (sel)
      SEL_PAGE: begin
        rd_val[8 +: PAGE_W] = page_q;
        rd_val[0]           = en_q;
      end
      SEL_CMD: begin
        rd_val[8 +: OFS_W] = ofs_q;
        rd_val[1]          = rd_busy;
        rd_val[0]          = wr_busy;
      end
      SEL_DATA: rd_val = stage_word;
      default:  rd_val = '0;
    endcase
  end

  // R5: registered read response
  always_ff @(posedge clk) begin
    if (rst) begin
      mg_rvalid <= 1'b0;
      mg_rdata  <= '0;
    end else begin
      mg_rvalid <= rd_hit;
      mg_rdata  <= rd_hit ? rd_val : '0;
    end
  end
endmodule

// File: rtl/mwb_checker.sv
module mwb_checker
  import mwb_pkg::*;
#(
  parameter logic [4:0] OWN_PHY = 5'd30,
  parameter int         PAGE_W  = 8,
  parameter int         OFS_W   = 8,
  parameter int         WORD_W  = 16,
  parameter int         DATA_W  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              mg_wr,
  input logic              mg_rd,
  input logic [4:0]        mg_phy,
  input logic [4:0]        mg_reg,
  input logic [1:0]        op_bits,
  input logic              mg_rvalid,
  input logic [WORD_W-1:0] mg_rdata,
  input logic              ib_req,
  input logic              ib_ack,
  input logic              ib_we,
  input logic [PAGE_W-1:0] ib_page,
  input logic [OFS_W-1:0]  ib_offset,
  input logic [DATA_W-1:0] ib_wdata
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!ib_req && !mg_rvalid));

  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (ib_req && !ib_ack) |=> ib_req);

  p_req_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (ib_req && !ib_ack) |=> ($stable(ib_page) && $stable(ib_offset)
                             && $stable(ib_we) && $stable(ib_wdata)));

  p_req_release_r4: assert property (@(posedge clk) disable iff (rst)
    (ib_req && ib_ack) |=> !ib_req);

  p_read_answer_r5: assert property (@(posedge clk) disable iff (rst)
    (mg_rd && mg_phy == OWN_PHY) |=> mg_rvalid);

  p_foreign_silent_r8: assert property (@(posedge clk) disable iff (rst)
    (mg_rd && mg_phy != OWN_PHY) |=> !mg_rvalid);

  p_both_bits_rejected_r9: assert property (@(posedge clk) disable iff (rst)
    (!ib_req && mg_wr && mg_phy == OWN_PHY && mg_reg == RA_CMD && op_bits == 2'b11)
      |=> !ib_req);

  p_unimpl_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (mg_rd && mg_phy == OWN_PHY && mg_reg == 5'h12) |=> (mg_rdata == '0));
endmodule

bind mgmt_window_bridge mwb_checker #(
  .OWN_PHY (OWN_PHY),
  .PAGE_W  (PAGE_W),
  .OFS_W   (OFS_W),
  .WORD_W  (WORD_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mg_wr     (mg_wr),
  .mg_rd     (mg_rd),
  .mg_phy    (mg_phy),
  .mg_reg    (mg_reg),
  .op_bits   (mg_wdata[1:0]),
  .mg_rvalid (mg_rvalid),
  .mg_rdata  (mg_rdata),
  .ib_req    (ib_req),
  .ib_ack    (ib_ack),
  .ib_we     (ib_we),
  .ib_page   (ib_page),
  .ib_offset (ib_offset),
  .ib_wdata  (ib_wdata)
);

// File: tb/mgmt_window_bridge_test.sv
module mgmt_window_bridge_test;
  localparam logic [4:0] OWN = 5'd30;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mg_wr = 1'b0, mg_rd = 1'b0;
  logic [4:0]  mg_phy = '0, mg_reg = '0;
  logic [15:0] mg_wdata = '0;
  logic        mg_rvalid;
  logic [15:0] mg_rdata;
  logic        ib_req, ib_we;
  logic [7:0]  ib_page, ib_offset;
  logic [63:0] ib_wdata;
  logic        ib_ack = 1'b0;
  logic [63:0] ib_rdata = '0;

  always #5 clk = ~clk;

  mgmt_window_bridge #(.OWN_PHY(OWN)) uut (
    .clk(clk), .rst(rst), .mg_wr(mg_wr), .mg_rd(mg_rd), .mg_phy(mg_phy),
    .mg_reg(mg_reg), .mg_wdata(mg_wdata), .mg_rvalid(mg_rvalid),
    .mg_rdata(mg_rdata), .ib_req(ib_req), .ib_we(ib_we), .ib_page(ib_page),
    .ib_offset(ib_offset), .ib_wdata(ib_wdata), .ib_ack(ib_ack),
    .ib_rdata(ib_rdata)
  );

  int    compared = 0, mismatched = 0, cyc = 0;
  string tag = "R1";
  bit    started = 0;

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_page, m_ofs;
  logic        m_en, m_wb, m_rb, busy_pre;
  logic [15:0] m_data [4];
  logic        e_rvalid, e_req, e_we;
  logic [15:0] e_rdata;
  logic [7:0]  e_page, e_ofs;
  logic [63:0] e_wdata;

  function automatic logic [15:0] m_read(input logic [4:0] r);
    if (r == 5'h10) return {m_page, 7'b0, m_en};
    if (r == 5'h11) return {m_ofs, 6'b0, m_rb, m_wb};
    if (r >= 5'h18 && r <= 5'h1b) return m_data[r[1:0]];
    return 16'h0000;
  endfunction

  always @(posedge clk) begin
    cyc++;
    started = 1;
    if (rst) begin
      m_page = 0; m_en = 0; m_ofs = 0; m_wb = 0; m_rb = 0;
      for (int k = 0; k < 4; k++) m_data[k] = 0;
      e_rvalid = 0; e_rdata = 0; e_req = 0; e_we = 0;
      e_page = 0; e_ofs = 0; e_wdata = 0;
    end else begin
      busy_pre = m_wb | m_rb;
      e_rvalid = mg_rd && mg_phy == OWN;
      e_rdata  = e_rvalid ? m_read(mg_reg) : 16'h0;
      if (busy_pre && ib_ack) begin
        if (m_rb) for (int k = 0; k < 4; k++) m_data[k] = ib_rdata[16*k +: 16];
        m_wb = 0; m_rb = 0; e_req = 0;
      end
      if (mg_wr && mg_phy == OWN) begin
        if (mg_reg == 5'h10) begin
          m_page = mg_wdata[15:8]; m_en = mg_wdata[0];
        end else if (mg_reg == 5'h11 && !busy_pre) begin
          m_ofs = mg_wdata[15:8];
          if (mg_wdata[1:0] == 2'b01 || mg_wdata[1:0] == 2'b10) begin
            m_wb = mg_wdata[0]; m_rb = mg_wdata[1];
            e_req = 1; e_we = mg_wdata[0]; e_page = m_page; e_ofs = mg_wdata[15:8];
            e_wdata = {m_data[3], m_data[2], m_data[1], m_data[0]};
          end
        end else if (mg_reg >= 5'h18 && mg_reg <= 5'h1b && !busy_pre) begin
          m_data[mg_reg[1:0]] = mg_wdata;
        end
      end
    end
  end

  task automatic cmp(input string what, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      cmp("mg_rvalid", 64'(mg_rvalid), 64'(e_rvalid));
      if (e_rvalid) cmp("mg_rdata", 64'(mg_rdata), 64'(e_rdata));
      cmp("ib_req", 64'(ib_req), 64'(e_req));
      if (e_req) begin
        cmp("ib_we", 64'(ib_we), 64'(e_we));
        cmp("ib_page", 64'(ib_page), 64'(e_page));
        cmp("ib_offset", 64'(ib_offset), 64'(e_ofs));
        if (e_we) cmp("ib_wdata", ib_wdata, e_wdata);
      end
    end
  end

  // ---------------- internal register file responder ----------------
  logic [63:0] mem [logic [15:0]];
  int wait_cnt = 2, lat = 2;
  always @(negedge clk) begin
    if (rst) begin
      ib_ack = 0; ib_rdata = 64'hDEAD_BEEF_0BAD_F00D;
    end else if (ib_ack) begin
      ib_ack = 0; ib_rdata = 64'hDEAD_BEEF_0BAD_F00D;
    end else if (ib_req) begin
      if (wait_cnt == 0) begin
        if (ib_we) mem[{ib_page, ib_offset}] = ib_wdata;
        else if (mem.exists({ib_page, ib_offset})) ib_rdata = mem[{ib_page, ib_offset}];
        else ib_rdata = {ib_page, ib_offset, ~ib_page, ib_offset,
                         ib_offset ^ 8'h5A, ib_page, 16'h1234};
        ib_ack = 1;
        lat = (lat + 3) % 7;
        wait_cnt = lat;
      end else begin
        wait_cnt--;
      end
    end
  end

  // ---------------- host tasks (called just after a negedge) ----------------
  task automatic hwr(input logic [4:0] phy, input logic [4:0] r, input logic [15:0] d);
    mg_wr = 1; mg_phy = phy; mg_reg = r; mg_wdata = d;
    @(negedge clk);
    mg_wr = 0;
  endtask

  task automatic hrd(input logic [4:0] phy, input logic [4:0] r);
    mg_rd = 1; mg_phy = phy; mg_reg = r;
    @(negedge clk);
    mg_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poll_done;
    do hrd(OWN, 5'h11); while (m_wb | m_rb);
    idle(1);
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  logic [15:0] lf = 16'hACE1;

  initial begin
    idle(3);
    // R1: outputs quiet during reset
    tag = "R1";
    cmp("ib_req in reset", 64'(ib_req), 64'd0);
    cmp("mg_rvalid in reset", 64'(mg_rvalid), 64'd0);
    rst = 0;
    idle(1);
    hrd(OWN, 5'h10); hrd(OWN, 5'h11);
    for (int k = 0; k < 4; k++) hrd(OWN, 5'(5'h18 + k));
    idle(2);

    // R2: page register fields
    tag = "R2";
    hwr(OWN, 5'h10, 16'h3A01); hrd(OWN, 5'h10);
    hwr(OWN, 5'h10, 16'hFFFF); hrd(OWN, 5'h10);
    idle(1);

    // R5: staging words, word k at 0x18+k
    tag = "R5";
    hwr(OWN, 5'h18, 16'h1111); hwr(OWN, 5'h19, 16'h2222);
    hwr(OWN, 5'h1a, 16'h3333); hwr(OWN, 5'h1b, 16'h4444);
    for (int k = 0; k < 4; k++) hrd(OWN, 5'(5'h18 + k));

    // R6: internal write uses page latched at command; page change while busy ignored
    tag = "R6";
    hwr(OWN, 5'h10, 16'h1201);
    hwr(OWN, 5'h11, 16'h4401);
    hwr(OWN, 5'h10, 16'h7701);
    tag = "R3";
    poll_done();

    // R7: read back what was written, on page 0x12
    tag = "R7";
    hwr(OWN, 5'h10, 16'h1201);
    for (int k = 0; k < 4; k++) hwr(OWN, 5'(5'h18 + k), 16'h0);
    hwr(OWN, 5'h11, 16'h4402);
    poll_done();
    for (int k = 0; k < 4; k++) hrd(OWN, 5'(5'h18 + k));

    // R11: command and staging writes dropped while pending
    tag = "R11";
    hwr(OWN, 5'h11, 16'h5002);
    hwr(OWN, 5'h18, 16'hBAD0);
    hwr(OWN, 5'h11, 16'h5501);
    poll_done();
    hrd(OWN, 5'h11);
    for (int k = 0; k < 4; k++) hrd(OWN, 5'(5'h18 + k));

    // R9: both request bits rejected, offset stored
    tag = "R9";
    hwr(OWN, 5'h11, 16'h6603);
    hrd(OWN, 5'h11);
    idle(3);

    // R8: foreign PHY ignored
    tag = "R8";
    hwr(5'd3, 5'h10, 16'hBEEF);
    hwr(5'd3, 5'h11, 16'h0102);
    hrd(5'd3, 5'h10);
    hrd(OWN, 5'h10);
    idle(3);

    // R10: unimplemented addresses
    tag = "R10";
    hwr(OWN, 5'h12, 16'hFFFF);
    hrd(OWN, 5'h12); hrd(OWN, 5'h1c); hrd(OWN, 5'h00); hrd(OWN, 5'h1f);

    // R4: pseudo-random mix, many strobes landing inside busy windows
    tag = "R4";
    for (int i = 0; i < 300; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (lf[2:0])
        3'd0: hwr(OWN, 5'h10, {lf[11:10], 6'b0, 7'b0, lf[3]});
        3'd1: hwr(OWN, 5'(5'h18 + lf[5:4]), lf ^ 16'h9C3F);
        3'd2: hwr(OWN, 5'h11, {6'b0, lf[9:8], 8'h01});
        3'd3: hwr(OWN, 5'h11, {6'b0, lf[9:8], 8'h02});
        3'd4: hrd(OWN, (lf[6] ? 5'(5'h18 + lf[5:4]) : (lf[5] ? 5'h11 : 5'h10)));
        3'd5: poll_done();
        3'd6: hwr(OWN, 5'h11, {lf[15:8], 8'h03});
        default: hwr(5'(lf[7:3]) == OWN ? 5'd1 : 5'(lf[7:3]), 5'h11, 16'h0001);
      endcase
    end
    poll_done();
    idle(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule